// File: doc/BRIEF.md
# Chien Search and Forney Error Evaluator

This block takes the error locator polynomial Λ(x) and the error magnitude polynomial Ω(x) of a Reed-Solomon decoder over GF(2^8), both presented as parallel coefficient vectors, and turns them into a stream of error values. A one-cycle start pulse captures both polynomials. For the next N cycles the block tests one candidate location per cycle. It raises a location bit where Λ has a root and presents the matching error value from the x-scaled Forney formula. The value is zero wherever no error is found.

Λ is evaluated by T+1 register stages. Each stage scales its own coefficient by a fixed power of α once per cycle. The sum of the odd-indexed stages alone is taken as the Forney denominator xΛ'(x). A second bank of T+1 stages evaluates xΩ(x) as the numerator. The denominator goes through a field inverse and is multiplied by the numerator. The product is gated by the root detector. At the end of the sweep a done strobe reports the number of roots found. It also reports a failure flag, which is set when that count differs from the degree of Λ. When more than T symbols are in error, the flag catches most cases but not all.

The error values leave the block in the reverse of the received symbol order: location index i is the symbol whose power of x in the received polynomial is i. A downstream stack and adder, not part of this block, apply the correction.

Top module: `rs_chien_forney`

## Requirements
- R1: While rst_n is low, and after it is released until the first start, loc_valid, loc_err, err_val, done, root_cnt and dec_fail are all zero.
- R2: A start sampled at a clock edge makes loc_valid high for exactly N consecutive cycles, beginning with the next cycle. loc_idx counts 0, 1, …, N-1 over those cycles.
- R3: The field is GF(2^8) with modulus x^8+x^4+x^3+x^2+1 and α = 8'h02. Coefficient j of Λ sits at lambda_in[8j+7:8j], and coefficient j of Ω sits at omega_in[8j+7:8j]. In a valid cycle, loc_err is 1 exactly when Λ(α^-loc_idx) = 0, and loc_err is 0 outside valid cycles.
- R4: When loc_err is 1, err_val equals xΩ(x) · (xΛ'(x))^-1 at x = α^-loc_idx. Here xΩ(x) = Σ Ω_j x^(j+1) and xΛ'(x) = Σ over odd j of Λ_j x^j.
- R5: err_val is zero in every cycle where loc_err is 0, including all cycles outside the sweep.
- R6: The inverse of zero is taken as zero, so a root at which xΛ'(x) = 0 (a repeated root) yields err_val = 0 while loc_err is 1.
- R7: done is high for one cycle, the cycle after the last valid cycle. During that cycle root_cnt equals the number of valid cycles in which loc_err was 1.
- R8: At done, dec_fail is 1 exactly when root_cnt differs from the degree of Λ. The degree is the highest index j with a nonzero Λ_j, and it is 0 if there is none.
- R9: A start clears root_cnt and dec_fail at the same edge. After the sweep, both hold their values until the next start.
- R10: A start during a sweep restarts the sweep with the newly presented coefficients: loc_idx returns to 0, the count restarts, and no done is produced for the abandoned sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture coefficients and begin a sweep |
| lambda_in | input | 8*(T+1) | Error locator coefficients, index j at bits 8j+7:8j |
| omega_in | input | 8*(T+1) | Error magnitude coefficients, index j at bits 8j+7:8j |
| loc_valid | output | 1 | A candidate location is being reported |
| loc_err | output | 1 | Current location is a root of Λ |
| loc_idx | output | clog2(N) | Current location index |
| err_val | output | 8 | Error value for the current location, zero where no error |
| done | output | 1 | One-cycle end-of-sweep strobe |
| root_cnt | output | clog2(N+1) | Roots found in the sweep |
| dec_fail | output | 1 | Root count differs from degree of Λ |

## Verification
The bench places roots at location 0 and at location N-1 to catch an off-by-one in the first-cycle load or in the sweep length. A design that got this wrong would miss or misplace those edge errors. A squared linear factor gives a root where xΛ'(x) vanishes. A design that did not map the inverse of zero to zero would emit a nonzero value there, and a design that mishandled the degree or count would leave the failure flag clear. An all-zero Λ makes every location a root and drives the count to its maximum, which exposes a counter that is too narrow. A start issued in the middle of a sweep checks that the old count is dropped and that no stray done appears.

// File: rtl/rsce_pkg.sv
package rsce_pkg;
  localparam int SW = 8;
  localparam int ORD = 255;
  localparam logic [SW-1:0] POLY_LO = 8'h1D;

  typedef logic [SW-1:0] sym_t;

  // generic product: shift-and-xor network reduced by the field modulus
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t sh;
    acc = '0;
    sh  = a;
    for (int k = 0; k < SW; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = sh[SW-1] ? ({sh[SW-2:0], 1'b0} ^ POLY_LO) : {sh[SW-2:0], 1'b0};
    end
    return acc;
  endfunction

  // alpha raised to a constant power, used for the fixed stage multipliers
  function automatic sym_t gf_alpha_pow(int e);
    sym_t r;
    r = 8'h01;
    for (int k = 0; k < e; k++) r = gf_mul(r, 8'h02);
    return r;
  endfunction

  // a^254 through seven squarings; zero maps to zero
  function automatic sym_t gf_inv(sym_t a);
    sym_t sq;
    sym_t r;
    sq = a;
    r  = 8'h01;
    for (int k = 1; k < SW; k++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction
endpackage

// File: rtl/rsce_chien_cell.sv
module rsce_chien_cell
  import rsce_pkg::*;
#(
  parameter int EXP = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  input  sym_t coef,
  output sym_t term
);
  localparam sym_t MULT = gf_alpha_pow(EXP);

  sym_t term_q;
  sym_t term_n;
  logic en;

  assign en = load | step;

  always_comb begin
    term_n = term_q;
    if (load)      term_n = coef;
    else if (step) term_n = gf_mul(term_q, MULT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  term_q <= '0;
    else if (en) term_q <= term_n;
  end

  assign term = term_q;
endmodule

// File: rtl/rsce_gf_inverse.sv
module rsce_gf_inverse
  import rsce_pkg::*;
(
  input  sym_t a,
  output sym_t inv
);
  assign inv = gf_inv(a);
endmodule

// File: rtl/rsce_search_ctrl.sv
module rsce_search_ctrl #(
  parameter int N  = 255,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          run,
  output logic [IW-1:0] idx,
  output logic          last,
  output logic          done
);
  logic          run_q, run_n;
  logic [IW-1:0] idx_q, idx_n;
  logic          done_q, done_n;

  assign last = run_q && (idx_q == IW'(N - 1));

  always_comb begin
    run_n  = run_q;
    idx_n  = idx_q;
    done_n = 1'b0;
    if (start) begin
      run_n = 1'b1;
      idx_n = '0;
    end else if (run_q) begin
      if (last) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end else begin
        idx_n = idx_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_n;
      idx_q  <= idx_n;
      done_q <= done_n;
    end
  end

  assign run  = run_q;
  assign idx  = idx_q;
  assign done = done_q;

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !start && idx_q != IW'(N - 1)) |=> (run_q && idx_q == $past(idx_q) + IW'(1)));
  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && idx_q == '0 && !done_q));
  // R7
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(run_q) && $past(idx_q) == IW'(N - 1) && !run_q));
endmodule

// File: rtl/rsce_root_tally.sv
module rsce_root_tally
  import rsce_pkg::*;
#(
  parameter int T  = 8,
  parameter int CW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [(T+1)*SW-1:0]  lambda_in,
  input  logic                 hit,
  input  logic                 finish,
  output logic [CW-1:0]        cnt,
  output logic                 fail
);
  logic [CW-1:0] deg_c, deg_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          fail_q, fail_n;

  // degree: index of the highest nonzero locator coefficient
  always_comb begin
    deg_c = '0;
    for (int j = 1; j <= T; j++)
      if (lambda_in[j*SW +: SW] != '0) deg_c = CW'(j);
  end

  always_comb begin
    cnt_n  = cnt_q;
    fail_n = fail_q;
    if (start) begin
      cnt_n  = '0;
      fail_n = 1'b0;
    end else begin
      if (hit) cnt_n = cnt_q + CW'(1);
      if (finish) fail_n = (cnt_n != deg_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     deg_q <= '0;
    else if (start) deg_q <= deg_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      fail_q <= fail_n;
    end
  end

  assign cnt  = cnt_q;
  assign fail = fail_q;

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !hit && !finish) |=> ($stable(cnt_q) && $stable(fail_q)));
endmodule

// File: rtl/rs_chien_forney.sv
module rs_chien_forney
  import rsce_pkg::*;
#(
  parameter int T = 8,
  parameter int N = 255,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(N + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [(T+1)*8-1:0]   lambda_in,
  input  logic [(T+1)*8-1:0]   omega_in,
  output logic                 loc_valid,
  output logic                 loc_err,
  output logic [IW-1:0]        loc_idx,
  output logic [7:0]           err_val,
  output logic                 done,
  output logic [CW-1:0]        root_cnt,
  output logic                 dec_fail
);
  localparam int NS = T + 1;

  logic run;
  logic last;
  logic finish;

  sym_t lam_term [NS];
  sym_t om_term  [NS];
  sym_t lam_sum, odd_sum, om_sum;
  sym_t den_inv;
  sym_t quot;

  rsce_search_ctrl #(.N(N), .IW(IW)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .run   (run),
    .idx   (loc_idx),
    .last  (last),
    .done  (done)
  );

  // locator stage j steps by alpha^-j, magnitude stage j by alpha^-(j+1)
  for (genvar j = 0; j < NS; j++) begin : g_stage
    rsce_chien_cell #(.EXP((ORD - j) % ORD)) u_lam (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .step  (run),
      .coef  (lambda_in[j*SW +: SW]),
      .term  (lam_term[j])
    );
    rsce_chien_cell #(.EXP((ORD - j - 1) % ORD)) u_om (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .step  (run),
      .coef  (omega_in[j*SW +: SW]),
      .term  (om_term[j])
    );
  end

  always_comb begin
    lam_sum = '0;
    odd_sum = '0;
    om_sum  = '0;
    for (int j = 0; j < NS; j++) begin
      lam_sum = lam_sum ^ lam_term[j];
      om_sum  = om_sum ^ om_term[j];
      if (j % 2 == 1) odd_sum = odd_sum ^ lam_term[j];
    end
  end

  rsce_gf_inverse u_inv (
    .a   (odd_sum),
    .inv (den_inv)
  );

  assign quot      = gf_mul(om_sum, den_inv);
  assign loc_valid = run;
  assign loc_err   = run && (lam_sum == '0);
  assign err_val   = loc_err ? quot : '0;
  assign finish    = last && !start;

  rsce_root_tally #(.T(T), .CW(CW)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .lambda_in (lambda_in),
    .hit       (loc_err),
    .finish    (finish),
    .cnt       (root_cnt),
    .fail      (dec_fail)
  );

  // R4
  inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && odd_sum != '0) |-> (gf_mul(odd_sum, den_inv) == 8'h01));
  // R3
  err_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_err |-> (loc_valid && !done));
endmodule

// File: tb/rs_chien_forney_tb.sv
module rs_chien_forney_tb;
  localparam int T  = 8;
  localparam int N  = 255;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic clk;
  logic rst_n;
  logic start;
  logic [(T+1)*8-1:0] lam_v;
  logic [(T+1)*8-1:0] om_v;
  logic loc_valid, loc_err, done, dec_fail;
  logic [IW-1:0] loc_idx;
  logic [7:0] err_val;
  logic [CW-1:0] root_cnt;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // reference state
  int  m_lam [T+1];
  int  m_om  [T+1];
  bit  m_act  = 0;
  int  m_idx  = 0;
  bit  m_done = 0;
  int  m_cnt  = 0;
  bit  m_fail = 0;
  bit  restarted = 0;

  rs_chien_forney #(.T(T), .N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .lambda_in(lam_v), .omega_in(om_v),
    .loc_valid(loc_valid), .loc_err(loc_err), .loc_idx(loc_idx),
    .err_val(err_val), .done(done), .root_cnt(root_cnt), .dec_fail(dec_fail)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic int gmul(int a, int b);
    int r = 0;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) r = r ^ a;
      a = a << 1;
      if (a & 256) a = a ^ 285;
    end
    return r;
  endfunction

  function automatic int apow(int e);
    int r = 1;
    for (int k = 0; k < e; k++) r = gmul(r, 2);
    return r;
  endfunction

  function automatic int ginv(int a);
    if (a == 0) return 0;
    for (int b = 1; b < 256; b++) if (gmul(a, b) == 1) return b;
    return 0;
  endfunction

  // value of a polynomial (Horner) at x
  function automatic int lam_at(int x);
    int acc = 0;
    for (int j = T; j >= 0; j--) acc = gmul(acc, x) ^ m_lam[j];
    return acc;
  endfunction

  function automatic int den_at(int x);
    int acc = 0;
    int xp = 1;
    for (int j = 0; j <= T; j++) begin
      if (j % 2 == 1) acc = acc ^ gmul(m_lam[j], xp);
      xp = gmul(xp, x);
    end
    return acc;
  endfunction

  function automatic int num_at(int x);
    int acc = 0;
    int xp = x;
    for (int j = 0; j <= T; j++) begin
      acc = acc ^ gmul(m_om[j], xp);
      xp = gmul(xp, x);
    end
    return acc;
  endfunction

  function automatic int lam_deg();
    int d = 0;
    for (int j = 1; j <= T; j++) if (m_lam[j] != 0) d = j;
    return d;
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: act=%0d exp=%0d", tag, cyc, act, expv);
    end
  endtask

  // reference model advance
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_act = 0; m_idx = 0; m_done = 0; m_cnt = 0; m_fail = 0;
    end else if (start) begin
      for (int j = 0; j <= T; j++) begin
        m_lam[j] = int'(lam_v[j*8 +: 8]);
        m_om[j]  = int'(om_v[j*8 +: 8]);
      end
      m_act = 1; m_idx = 0; m_done = 0; m_cnt = 0; m_fail = 0;
    end else if (m_act) begin
      if (lam_at(apow((255 - m_idx) % 255)) == 0) m_cnt++;
      if (m_idx == N - 1) begin
        m_act = 0; m_done = 1;
        m_fail = (m_cnt != lam_deg());
      end else begin
        m_idx++;
      end
    end else begin
      m_done = 0;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(loc_valid == m_act, "R2 valid", loc_valid, m_act);
      if (m_act) begin
        int x, lv, dv, nv, ev;
        bit e;
        x  = apow((255 - m_idx) % 255);
        lv = lam_at(x);
        dv = den_at(x);
        nv = num_at(x);
        e  = (lv == 0);
        ev = e ? gmul(nv, ginv(dv)) : 0;
        chk(loc_idx == IW'(m_idx), "R2 idx", loc_idx, m_idx);
        chk(loc_err == e, "R3 loc", loc_err, e);
        if (e && dv == 0) chk(err_val == 0, "R6 zero-den", err_val, 0);
        else if (e) chk(int'(err_val) == ev, "R4 value", err_val, ev);
        else chk(err_val == 0, "R5 gated", err_val, 0);
      end else begin
        chk(loc_err == 0, "R3 idle", loc_err, 0);
        chk(err_val == 0, "R5 idle", err_val, 0);
      end
      chk(done == m_done, "R7 done", done, m_done);
      if (m_done) chk(int'(root_cnt) == m_cnt, "R7 count", root_cnt, m_cnt);
      else if (!m_act) chk(int'(root_cnt) == m_cnt, "R9 hold", root_cnt, m_cnt);
      if (m_done) chk(dec_fail == m_fail, "R8 fail", dec_fail, m_fail);
      else chk(dec_fail == m_fail, "R9 fail", dec_fail, m_fail);
    end
  end

  task automatic set_roots(int roots[$]);
    int c [T+1];
    int a;
    for (int j = 0; j <= T; j++) c[j] = 0;
    c[0] = 1;
    foreach (roots[r]) begin
      a = apow(roots[r]);
      for (int j = T; j >= 1; j--) c[j] = c[j] ^ gmul(a, c[j-1]);
    end
    for (int j = 0; j <= T; j++) lam_v[j*8 +: 8] = 8'(c[j]);
  endtask

  task automatic set_omega(int seed);
    for (int j = 0; j <= T; j++) om_v[j*8 +: 8] = 8'((seed * (j + 3) * 37 + j * 11) % 256);
  endtask

  task automatic pulse();
    @(posedge clk); #2 start = 1;
    @(posedge clk); #2 start = 0;
  endtask

  task automatic finish_run();
    wait (m_act == 0);
    repeat (6) @(posedge clk);
    #2;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; start = 0; lam_v = '0; om_v = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(loc_valid == 0 && loc_err == 0 && err_val == 0, "R1 outputs", loc_valid, 0);
    chk(done == 0 && root_cnt == 0 && dec_fail == 0, "R1 status", root_cnt, 0);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
    #2;
    // single error
    set_roots('{5}); set_omega(1); pulse(); finish_run();
    // boundary locations 0 and N-1 plus a middle one
    set_roots('{0, 254, 100}); set_omega(2); pulse(); finish_run();
    // four errors
    set_roots('{3, 77, 150, 200}); set_omega(3); pulse(); finish_run();
    // full capacity, T errors
    set_roots('{10, 20, 31, 47, 88, 120, 199, 230}); set_omega(4); pulse(); finish_run();
    // no error: Lambda = 1
    set_roots('{}); set_omega(5); pulse(); finish_run();
    chk(dec_fail == 0 && root_cnt == 0, "R8 clean", root_cnt, 0);
    // repeated root: zero denominator at the root, failure expected
    set_roots('{3, 3}); set_omega(6); pulse(); finish_run();
    chk(dec_fail == 1 && root_cnt == 1, "R6 R8 repeated", root_cnt, 1);
    // all-zero locator: every location a root
    lam_v = '0; set_omega(7); pulse(); finish_run();
    chk(int'(root_cnt) == N && dec_fail == 1, "R7 R8 all-roots", root_cnt, N);
    // arbitrary degree-2 locator
    lam_v = '0; lam_v[7:0] = 8'h01; lam_v[15:8] = 8'h37; lam_v[23:16] = 8'h91;
    set_omega(8); pulse(); finish_run();
    // restart in mid-sweep
    set_roots('{5}); set_omega(9); pulse();
    repeat (50) @(posedge clk);
    #2 set_roots('{0, 254}); set_omega(10);
    pulse();
    @(negedge clk);
    chk(loc_idx == 0 && loc_valid, "R10 restart", loc_idx, 0);
    finish_run();
    chk(root_cnt == 2 && dec_fail == 0, "R10 count", root_cnt, 2);
    // hold after the sweep
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(root_cnt == 2 && done == 0, "R9 long hold", root_cnt, 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule